// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous static RAM with registered inputs and registered outputs, as used for cache or buffer storage in a larger chip. Every command (address, chip select, write enable, per-lane write enables) is taken on the rising clock edge. A read returns its word one cycle after the address is captured. A write is late: its data is taken on the edge after its command, and it is then held in a pending register until the next write's data arrives. Reads that hit the pending address are served through a per-lane compare-and-merge path, so a read always sees the latest write.

The data bus is built from 9-bit lanes, each with its own active-low write enable. The bidirectional bus is split into `din`, `dout` and a drive enable `dq_oe`. An asynchronous active-low output enable gates the drive directly. A sleep input stops the block through a short entry window and a fixed two-cycle recovery window, and the stored contents are kept.

Top module: `late_write_sram`

## Requirements
- R1: After reset no lane is driven, no write is pending, and every word reads as zero.
- R2: A read (`cs_n`=0, `we_n`=1) sampled at edge k loads `dout` at edge k+1, and `dq_oe` is high in that slot while `oe_n` is low.
- R3: A deselect (`cs_n`=1) sampled at edge k leaves `dq_oe` low in the slot after edge k+1.
- R4: A write command sampled at edge k takes its data from `din` at edge k+1. Lane l (bits 9l+8 down to 9l) is written only when `be_n[l]`=0, and the other lanes keep their contents.
- R5: A read sees every earlier write, including a write whose command came on the edge just before it. Only the lanes that write enabled are taken from it, and the rest come from older contents.
- R6: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R7: The output slot that follows a write command is never driven, even with `oe_n` low.
- R8: From the first edge that samples `sleep` high, no lane is driven. Commands sampled at later edges while asleep are ignored, and the memory is preserved.
- R9: Once `sleep` is sampled low at edge f, commands at edges f, f+1 and f+2 are ignored, and a write there changes nothing. The first command accepted is at edge f+3.
- R10: A write command is never sampled on the edge right after an accepted read; at least one dead cycle separates them (protocol rule).
- R11: `cs_n` is high at the edge where `sleep` is first sampled high (protocol rule).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write command |
| be_n | input | LANES | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high sleep request |
| din | input | LANES*9 | Write data, taken one edge after its command |
| dout | output | LANES*9 | Registered read data |
| dq_oe | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The bench goes after a read issued on the very edge after a write to the same word, and after a second partial write stacked on the first. A design without forwarding returns stale array data there, and one that merges whole words instead of lanes corrupts the lanes that were not enabled. It counts the ignored edges around sleep release exactly, where an off-by-one recovery window lets the write made during recovery overwrite the preserved word. It toggles `oe_n` between edges, which catches a registered output enable, and checks the write and deselect slots for bus contention.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANE_W = 9;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic [2:0] {
        PH_AWAKE,
        PH_ENTER,
        PH_ASLEEP,
        PH_WAKE1,
        PH_WAKE2
    } phase_e;

    // Sleep sequencing: one entry step, then two recovery steps after release.
    function automatic phase_e phase_next(input phase_e cur, input logic slp);
        case (cur)
            PH_AWAKE:  return slp ? PH_ENTER  : PH_AWAKE;
            PH_ENTER:  return slp ? PH_ASLEEP : PH_AWAKE;
            PH_ASLEEP: return slp ? PH_ASLEEP : PH_WAKE1;
            PH_WAKE1:  return slp ? PH_ASLEEP : PH_WAKE2;
            PH_WAKE2:  return slp ? PH_ASLEEP : PH_AWAKE;
            default:   return PH_AWAKE;
        endcase
    endfunction

    // Per-lane forwarding choice.
    function automatic lane_t lane_pick(input logic take_new, input lane_t newer, input lane_t older);
        return take_new ? newer : older;
    endfunction

endpackage

// File: rtl/lw_sleep_fsm.sv
module lw_sleep_fsm
    import lw_sram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep,
    output phase_e phase
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_AWAKE;
        else     phase_q <= phase_next(phase_q, sleep);
    end

    assign phase = phase_q;
endmodule

// File: rtl/lw_write_pipe.sv
module lw_write_pipe
    import lw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 4,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be_n,
    input  logic [DW-1:0]     din,
    output logic              stage_valid,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [LANES-1:0]  pend_en,
    output logic [DW-1:0]     pend_data,
    output logic              commit
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  en;
    } wcmd_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  en;
        logic [DW-1:0]     data;
    } wpend_t;

    wcmd_t  stage_q;
    wpend_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            pend_q  <= '0;
        end else begin
            stage_q.valid <= wr_cmd;
            stage_q.addr  <= addr;
            stage_q.en    <= ~be_n;
            if (stage_q.valid) begin
                pend_q.valid <= 1'b1;
                pend_q.addr  <= stage_q.addr;
                pend_q.en    <= stage_q.en;
                pend_q.data  <= din;
            end
        end
    end

    // The held write retires into the array when the next write's data lands.
    assign commit      = stage_q.valid && pend_q.valid;
    assign stage_valid = stage_q.valid;
    assign pend_valid  = pend_q.valid;
    assign pend_addr   = pend_q.addr;
    assign pend_en     = pend_q.en;
    assign pend_data   = pend_q.data;
endmodule

// File: rtl/lw_array.sv
module lw_array
    import lw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 4,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wen,
    input  logic [DW-1:0]     wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && wen[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/lw_read_out.sv
module lw_read_out
    import lw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 4,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     arr_rdata,
    input  logic              pend_valid,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [LANES-1:0]  pend_en,
    input  logic [DW-1:0]     pend_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     dout,
    output logic              drive
);
    logic              rd_valid_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DW-1:0]     merged;
    logic              hit;

    assign hit = pend_valid && (pend_addr == rd_addr_q);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] =
            lane_pick(hit && pend_en[g],
                      pend_data[g*LANE_W +: LANE_W],
                      arr_rdata[g*LANE_W +: LANE_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_addr_q  <= '0;
            dout       <= '0;
            drive      <= 1'b0;
        end else begin
            rd_valid_q <= rd_cmd;
            rd_addr_q  <= addr;
            drive      <= rd_valid_q;
            if (rd_valid_q) dout <= merged;
        end
    end

    assign rd_addr = rd_addr_q;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
    import lw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 4,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dq_oe
);
    phase_e            phase;
    logic              awake;
    logic              rd_cmd;
    logic              wr_cmd;
    logic              wr_stage_valid;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_en;
    logic [DW-1:0]     pend_data;
    logic              commit;
    logic [ADDR_W-1:0] rd_addr;
    logic [DW-1:0]     arr_rdata;
    logic              drive;

    lw_sleep_fsm u_sleep (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .phase (phase)
    );

    assign awake  = (phase == PH_AWAKE);
    assign rd_cmd = awake && !cs_n &&  we_n;
    assign wr_cmd = awake && !cs_n && !we_n;

    lw_write_pipe #(.LANES(LANES), .ADDR_W(ADDR_W)) u_wpipe (
        .clk         (clk),
        .rst         (rst),
        .wr_cmd      (wr_cmd),
        .addr        (addr),
        .be_n        (be_n),
        .din         (din),
        .stage_valid (wr_stage_valid),
        .pend_valid  (pend_valid),
        .pend_addr   (pend_addr),
        .pend_en     (pend_en),
        .pend_data   (pend_data),
        .commit      (commit)
    );

    lw_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (pend_addr),
        .wen   (pend_en),
        .wdata (pend_data),
        .raddr (rd_addr),
        .rdata (arr_rdata)
    );

    lw_read_out #(.LANES(LANES), .ADDR_W(ADDR_W)) u_rdout (
        .clk        (clk),
        .rst        (rst),
        .rd_cmd     (rd_cmd),
        .addr       (addr),
        .arr_rdata  (arr_rdata),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_en    (pend_en),
        .pend_data  (pend_data),
        .rd_addr    (rd_addr),
        .dout       (dout),
        .drive      (drive)
    );

    // Output enable acts without a clock; any non-awake phase floats the bus.
    assign dq_oe = drive && !oe_n && awake;
endmodule

// File: rtl/lw_sram_checker.sv
module lw_sram_checker
    import lw_sram_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cs_n,
    input logic   we_n,
    input logic   oe_n,
    input logic   sleep,
    input logic   dq_oe,
    input phase_e phase,
    input logic   wr_stage
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!dq_oe && !wr_stage));

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && phase == PH_AWAKE && !sleep) |-> ##2 (oe_n || dq_oe || phase != PH_AWAKE));

    assert_deselect_float_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> ##2 !dq_oe);

    assert_oe_gate_R6: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    assert_write_float_R7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !we_n) |-> ##2 !dq_oe);

    assert_sleep_float_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ASLEEP) |-> !dq_oe);

    assert_recovery_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_AWAKE) |=> !wr_stage);

    assert_dead_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && we_n && phase == PH_AWAKE) |=> !(!cs_n && !we_n));

    assert_sleep_deselect_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep) |-> cs_n);
endmodule

bind late_write_sram lw_sram_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .dq_oe    (dq_oe),
    .phase    (phase),
    .wr_stage (wr_stage_valid)
);

// File: tb/sim_late_write_sram.sv
`timescale 1ns/100ps
module sim_late_write_sram;
    localparam int LANES  = 2;
    localparam int ADDR_W = 4;
    localparam int W      = LANES * 9;
    localparam int DEPTH  = 16;

    logic              clk;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic              cs_n;
    logic              we_n;
    logic [LANES-1:0]  be_n;
    logic              oe_n;
    logic              sleep;
    logic [W-1:0]      din;
    logic [W-1:0]      dout;
    logic              dq_oe;

    late_write_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .we_n(we_n), .be_n(be_n),
        .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    run    = 0;
    string cur_req = "R1";
    logic [W-1:0] nd = '0;

    // Behavioural reference: memory with writes applied in command order.
    logic [W-1:0]      m_mem [DEPTH];
    int                m_ph;
    bit                m_wpend, m_rpend, m_drv;
    logic [ADDR_W-1:0] m_wa, m_ra;
    logic [LANES-1:0]  m_wbe;
    logic [W-1:0]      m_dout;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_wpend = 0; m_rpend = 0; m_drv = 0; m_dout = '0;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        end else begin
            if (m_wpend)
                for (int l = 0; l < LANES; l++)
                    if (!m_wbe[l]) m_mem[m_wa][l*9 +: 9] = din[l*9 +: 9];
            m_drv = m_rpend;
            if (m_rpend) m_dout = m_mem[m_ra];
            m_wpend = 0; m_rpend = 0;
            if (m_ph == 0 && !cs_n) begin
                if (we_n) begin m_rpend = 1; m_ra = addr; end
                else begin m_wpend = 1; m_wa = addr; m_wbe = be_n; end
            end
            case (m_ph)
                0: m_ph = sleep ? 1 : 0;
                1: m_ph = sleep ? 2 : 0;
                2: m_ph = sleep ? 2 : 3;
                3: m_ph = sleep ? 2 : 4;
                default: m_ph = sleep ? 2 : 0;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        if (run && !rst) begin
            logic exp_oe;
            exp_oe = m_drv && !oe_n && (m_ph == 0);
            checks++;
            if (dq_oe !== exp_oe) begin
                fails++;
                $display("FAIL %s dq_oe actual=%b expected=%b t=%0t", cur_req, dq_oe, exp_oe, $time);
            end else if (exp_oe && dout !== m_dout) begin
                fails++;
                $display("FAIL %s dout actual=%h expected=%h t=%0t", cur_req, dout, m_dout, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic c, input logic w, input logic [ADDR_W-1:0] a,
                       input logic [LANES-1:0] be, input logic [W-1:0] d);
        @(negedge clk);
        cs_n = c; we_n = w; addr = a; be_n = be; din = nd; nd = d;
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, '0, '1, '0);
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [W-1:0] expv);
        cyc(1'b0, 1'b1, a, '1, '0);
        idle();
        @(negedge clk); #1;
        chk(req, {17'd0, dq_oe}, {17'd0, 1'b1});
        chk(req, dout, expv);
    endtask

    localparam logic [W-1:0] D_A = 18'h2A5A5;
    localparam logic [W-1:0] D_B = 18'h15A5A;
    localparam logic [W-1:0] D_1 = 18'h0F0F0;
    localparam logic [W-1:0] D_2 = 18'h3C3C3;

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        bit last_rd;
        rst = 1; cs_n = 1; we_n = 1; addr = '0; be_n = '1; oe_n = 0; sleep = 0; din = '0;
        repeat (3) @(negedge clk);
        rst = 0; run = 1;
        @(negedge clk); #1;
        chk("R1", {17'd0, dq_oe}, '0);
        rd_chk("R1", 4'd5, '0);

        cur_req = "R4";
        cyc(1'b0, 1'b0, 4'd1, 2'b00, D_A);
        cyc(1'b0, 1'b0, 4'd2, 2'b00, D_B);
        idle();
        rd_chk("R2", 4'd1, D_A);
        rd_chk("R2", 4'd2, D_B);
        cyc(1'b0, 1'b0, 4'd1, 2'b10, 18'h3FFFF);
        idle();
        rd_chk("R4", 4'd1, {D_A[17:9], 9'h1FF});

        cur_req = "R5";
        cyc(1'b0, 1'b0, 4'd3, 2'b00, D_1);
        rd_chk("R5", 4'd3, D_1);
        cyc(1'b0, 1'b0, 4'd3, 2'b01, D_2);
        rd_chk("R5", 4'd3, {D_2[17:9], D_1[8:0]});
        cyc(1'b0, 1'b0, 4'd4, 2'b00, 18'h00444);
        cyc(1'b0, 1'b0, 4'd5, 2'b00, 18'h05555);
        cyc(1'b0, 1'b0, 4'd6, 2'b00, 18'h36666);
        idle();
        rd_chk("R5", 4'd4, 18'h00444);
        rd_chk("R5", 4'd5, 18'h05555);
        rd_chk("R5", 4'd6, 18'h36666);

        cur_req = "R6";
        rd_chk("R6", 4'd2, D_B);
        #0.5 oe_n = 1;
        #0.2 chk("R6", {17'd0, dq_oe}, '0);
        oe_n = 0;

        cur_req = "R3";
        cyc(1'b0, 1'b1, 4'd2, '1, '0);
        idle();
        idle();
        @(negedge clk); #1;
        chk("R3", {17'd0, dq_oe}, '0);

        cur_req = "R7";
        cyc(1'b0, 1'b0, 4'd7, 2'b00, 18'h17777);
        idle();
        @(negedge clk); #1;
        chk("R7", {17'd0, dq_oe}, '0);

        cur_req = "R8";
        @(negedge clk); sleep = 1;
        idle();
        cyc(1'b0, 1'b1, 4'd1, '1, '0);
        idle();
        @(negedge clk); #1;
        chk("R8", {17'd0, dq_oe}, '0);
        cyc(1'b0, 1'b0, 4'd1, 2'b00, 18'h11111);
        idle();
        idle();

        cur_req = "R9";
        @(negedge clk); sleep = 0;
        cyc(1'b0, 1'b0, 4'd1, 2'b00, 18'h22222);
        idle(); idle(); idle();
        rd_chk("R9", 4'd1, {D_A[17:9], 9'h1FF});
        rd_chk("R8", 4'd7, 18'h17777);

        cur_req = "R2 R4 R5";
        lf = 16'hACE1;
        last_rd = 0;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            oe_n = lf[4] & lf[5] & lf[6];
            if (lf[1:0] == 2'd0) begin
                idle(); last_rd = 0;
            end else if (lf[1:0] == 2'd1) begin
                cyc(1'b0, 1'b1, lf[9:6], '1, '0); last_rd = 1;
            end else if (last_rd) begin
                idle(); last_rd = 0;
            end else begin
                cyc(1'b0, 1'b0, lf[9:6], lf[3:2], {lf[15:0], lf[11:10]}); last_rd = 0;
            end
        end
        oe_n = 0;
        idle(); idle(); idle();
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule